// File: doc/BRIEF.md
# Registered AHB-Lite Bridge with Optional Pass-Through

This block connects one AHB-Lite master bus to one AHB-Lite slave bus. In registered mode it holds the master's address phase and write data in flops. It then replays the transfer on the slave side, captures the slave's reply and returns it to the master. Registering cuts the long combinational paths between the two buses. The cost is added stall cycles.

The slave side advances at one master edge in every `RATIO` master cycles, where `RATIO` is 1, 2 or 4. The `s_tick` output marks those edges, and slave-side logic uses it as its clock enable. The divider restarts at each transfer, so the stall count of a transfer is a fixed number for each ratio.

When `BYPASS` is set at a 1:1 ratio, the bridge collapses to wires. The transfer then costs only the slave's own wait states. The bridge handles single beats with OKAY and ERROR replies. There is one master on the master bus and one slave on the slave bus.

Top module: `ahb_reg_bridge`

## Requirements
- R1: In registered mode `s_tick` is high for one master cycle in every `RATIO` master cycles while a transfer is on the slave side, and only on those cycles. The slave address phase stays stable until a tick edge. A zero-wait OKAY transfer shows exactly 3+W tick cycles, where W is the number of slave wait states.
- R2: With `BYPASS`=1 and `RATIO`=1, every signal passes straight through with no register. The master sees exactly W stall cycles on an OKAY transfer and W+1 on an ERROR transfer.
- R3: With `BYPASS`=1 and `RATIO` other than 1, the bypass setting has no effect and the bridge behaves exactly as registered mode at that ratio.
- R4: In registered mode `m_hready` is high in reset and idle. After an accepted address phase it is low for exactly 1+3·RATIO+W·RATIO cycles on an OKAY transfer, and then high with `m_hresp`=0.
- R5: The bridge forwards the address, write flag, lock flag and size to the slave with each transfer. Size codes are 00 byte, 01 halfword and 10 word. Each master transfer produces exactly one slave address phase. In registered mode that phase is always shown as NONSEQ (10), whether the master issued NONSEQ (10) or SEQ (11).
- R6: Master HTRANS IDLE (00) and BUSY (01) start no slave access. The slave bus stays IDLE and `m_hready` stays high.
- R7: Write data reaches the slave during its data phase. Read data from the slave is presented on `m_hrdata` in the cycle where `m_hready` returns high.
- R8: A slave ERROR reply reaches the master as the two-cycle sequence. First comes `m_hready`=0 with `m_hresp`=1, then `m_hready`=1 with `m_hresp`=1. In registered mode the stall is 2+4·RATIO+W·RATIO cycles, and an errored write changes no slave data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master-side clock |
| rst_n | input | 1 | Active-low reset |
| m_haddr | input | AW | Master address |
| m_htrans | input | 2 | Master transfer type |
| m_hwrite | input | 1 | Master write flag |
| m_hsize | input | 2 | Master transfer size |
| m_hlock | input | 1 | Master locked-sequence flag |
| m_hwdata | input | DW | Master write data |
| m_hrdata | output | DW | Read data to master |
| m_hready | output | 1 | Ready to master |
| m_hresp | output | 1 | Error response to master |
| s_tick | output | 1 | Slave-side clock enable |
| s_haddr | output | AW | Slave address |
| s_htrans | output | 2 | Slave transfer type |
| s_hwrite | output | 1 | Slave write flag |
| s_hsize | output | 2 | Slave transfer size |
| s_hlock | output | 1 | Slave locked-sequence flag |
| s_hwdata | output | DW | Slave write data |
| s_hrdata | input | DW | Slave read data |
| s_hreadyout | input | 1 | Slave ready output |
| s_hresp | input | 1 | Slave error response |
| s_hready | output | 1 | Bus ready seen by the slave |

## Verification
The bench sweeps slave wait states 0 to 2 across OKAY and ERROR replies, reads and writes, every size code and both lock values. It does this in five configurations: pass-through, registered at each ratio, and bypass requested at ratio 2.

A divider that free-runs, or that misses a state, shows up as a stall count or tick count off the formula. Such a design would still move data correctly.

A bypass that is not forced off at ratio 2 gives the pass-through stall count, and the bench flags it. An error relayed as a single cycle, or an errored write that still lands in memory, is caught through the reply sequence and a later read-back.

Driving BUSY must leave the slave access counter unchanged. A bridge that forwarded SEQ, or launched on BUSY, would be seen at the slave.

// File: rtl/ahb_brg_pkg.sv
package ahb_brg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WDAT,
      ST_LAUNCH,
      ST_SADDR,
      ST_SDATA,
      ST_ERR1,
      ST_ERR2
   } brg_state_e;

   localparam logic [1:0] TR_IDLE = 2'b00;
   localparam logic [1:0] TR_BUSY = 2'b01;
   localparam logic [1:0] TR_NSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ  = 2'b11;

   function automatic logic tr_starts(input logic [1:0] tr);
      return (tr == TR_NSEQ) || (tr == TR_SEQ);
   endfunction

endpackage

// File: rtl/ahb_brg_tick.sv
module ahb_brg_tick #(
   parameter int RATIO = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || (cnt_q == LAST)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == LAST);

   // R1: ticks are never adjacent when the ratio is above 1
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && (RATIO > 1)) |=> !tick_o);

endmodule

// File: rtl/ahb_brg_thru.sv
module ahb_brg_thru #(
   parameter int AW = 20,
   parameter int DW = 32
) (
   input  logic [AW-1:0] m_haddr_i,
   input  logic [1:0]    m_htrans_i,
   input  logic          m_hwrite_i,
   input  logic [1:0]    m_hsize_i,
   input  logic          m_hlock_i,
   input  logic [DW-1:0] m_hwdata_i,
   output logic [DW-1:0] m_hrdata_o,
   output logic          m_hready_o,
   output logic          m_hresp_o,
   output logic          s_tick_o,
   output logic [AW-1:0] s_haddr_o,
   output logic [1:0]    s_htrans_o,
   output logic          s_hwrite_o,
   output logic [1:0]    s_hsize_o,
   output logic          s_hlock_o,
   output logic [DW-1:0] s_hwdata_o,
   input  logic [DW-1:0] s_hrdata_i,
   input  logic          s_hreadyout_i,
   input  logic          s_hresp_i,
   output logic          s_hready_o
);
   assign s_tick_o   = 1'b1;
   assign s_haddr_o  = m_haddr_i;
   assign s_htrans_o = m_htrans_i;
   assign s_hwrite_o = m_hwrite_i;
   assign s_hsize_o  = m_hsize_i;
   assign s_hlock_o  = m_hlock_i;
   assign s_hwdata_o = m_hwdata_i;
   assign s_hready_o = s_hreadyout_i;
   assign m_hrdata_o = s_hrdata_i;
   assign m_hready_o = s_hreadyout_i;
   assign m_hresp_o  = s_hresp_i;
endmodule

// File: rtl/ahb_brg_pipe.sv
module ahb_brg_pipe
   import ahb_brg_pkg::*;
#(
   parameter int AW    = 20,
   parameter int DW    = 32,
   parameter int RATIO = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] m_haddr_i,
   input  logic [1:0]    m_htrans_i,
   input  logic          m_hwrite_i,
   input  logic [1:0]    m_hsize_i,
   input  logic          m_hlock_i,
   input  logic [DW-1:0] m_hwdata_i,
   output logic [DW-1:0] m_hrdata_o,
   output logic          m_hready_o,
   output logic          m_hresp_o,
   output logic          s_tick_o,
   output logic [AW-1:0] s_haddr_o,
   output logic [1:0]    s_htrans_o,
   output logic          s_hwrite_o,
   output logic [1:0]    s_hsize_o,
   output logic          s_hlock_o,
   output logic [DW-1:0] s_hwdata_o,
   input  logic [DW-1:0] s_hrdata_i,
   input  logic          s_hreadyout_i,
   input  logic          s_hresp_i,
   output logic          s_hready_o
);
   brg_state_e    state_q, state_d;
   logic [AW-1:0] addr_q;
   logic [1:0]    size_q;
   logic          wr_q;
   logic          lock_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic [1:0]    strans_q;
   logic          tick;
   logic          run;
   logic          open_slot;
   logic          accept;
   logic          slv_done;

   assign run       = (state_q == ST_LAUNCH) || (state_q == ST_SADDR) || (state_q == ST_SDATA);
   assign open_slot = (state_q == ST_IDLE) || (state_q == ST_ERR2);
   assign accept    = open_slot && tr_starts(m_htrans_i);
   assign slv_done  = (state_q == ST_SDATA) && tick && s_hreadyout_i;

   ahb_brg_tick #(.RATIO(RATIO)) tick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE, ST_ERR2: state_d = accept ? ST_WDAT : ST_IDLE;
         ST_WDAT:          state_d = ST_LAUNCH;
         ST_LAUNCH:        state_d = tick ? ST_SADDR : ST_LAUNCH;
         ST_SADDR:         state_d = tick ? ST_SDATA : ST_SADDR;
         ST_SDATA:         if (slv_done) state_d = s_hresp_i ? ST_ERR1 : ST_IDLE;
         ST_ERR1:          state_d = ST_ERR2;
         default:          state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         size_q   <= '0;
         wr_q     <= 1'b0;
         lock_q   <= 1'b0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         strans_q <= TR_IDLE;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= m_haddr_i;
            size_q <= m_hsize_i;
            wr_q   <= m_hwrite_i;
            lock_q <= m_hlock_i;
         end
         if (state_q == ST_WDAT) begin
            wdata_q <= m_hwdata_i;
         end
         if (slv_done) begin
            rdata_q <= s_hrdata_i;
         end
         if ((state_q == ST_LAUNCH) && tick) begin
            strans_q <= TR_NSEQ;
         end else if ((state_q == ST_SADDR) && tick) begin
            strans_q <= TR_IDLE;
         end
      end
   end

   assign m_hready_o = open_slot;
   assign m_hresp_o  = (state_q == ST_ERR1) || (state_q == ST_ERR2);
   assign m_hrdata_o = rdata_q;
   assign s_tick_o   = tick;
   assign s_haddr_o  = addr_q;
   assign s_htrans_o = strans_q;
   assign s_hwrite_o = wr_q;
   assign s_hsize_o  = size_q;
   assign s_hlock_o  = lock_q;
   assign s_hwdata_o = wdata_q;
   assign s_hready_o = s_hreadyout_i;

   // R5: one slave address phase per transfer, closed at the next tick
   p_one_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_htrans_o[1] && s_tick_o) |=> !s_htrans_o[1]);

   // R1: slave address phase holds between ticks
   p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_htrans_o[1] && !s_tick_o) |=> (s_htrans_o[1] && $stable(s_haddr_o)));

   // R4: master is stalled while the slave address phase is out
   p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s_htrans_o[1] |-> !m_hready_o);

   // R8: error is relayed as two cycles
   p_err_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_hresp_o && !m_hready_o) |=> (m_hresp_o && m_hready_o));

   // R6: idle or busy on the master leaves the slave bus idle
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_hready_o && !m_htrans_i[1]) |=> (s_htrans_o == TR_IDLE));

endmodule

// File: rtl/ahb_reg_bridge.sv
module ahb_reg_bridge #(
   parameter int AW     = 20,
   parameter int DW     = 32,
   parameter int RATIO  = 1,
   parameter bit BYPASS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] m_haddr,
   input  logic [1:0]    m_htrans,
   input  logic          m_hwrite,
   input  logic [1:0]    m_hsize,
   input  logic          m_hlock,
   input  logic [DW-1:0] m_hwdata,
   output logic [DW-1:0] m_hrdata,
   output logic          m_hready,
   output logic          m_hresp,
   output logic          s_tick,
   output logic [AW-1:0] s_haddr,
   output logic [1:0]    s_htrans,
   output logic          s_hwrite,
   output logic [1:0]    s_hsize,
   output logic          s_hlock,
   output logic [DW-1:0] s_hwdata,
   input  logic [DW-1:0] s_hrdata,
   input  logic          s_hreadyout,
   input  logic          s_hresp,
   output logic          s_hready
);
   localparam bit USE_THRU = BYPASS && (RATIO == 1);

   if (!((RATIO == 1) || (RATIO == 2) || (RATIO == 4))) begin : g_bad_ratio
      $error("ahb_reg_bridge: RATIO must be 1, 2 or 4");
   end
   if ((AW < 8) || (DW < 8)) begin : g_bad_width
      $error("ahb_reg_bridge: AW and DW must be at least 8");
   end

   if (USE_THRU) begin : g_thru
      ahb_brg_thru #(.AW(AW), .DW(DW)) core_i (
         .m_haddr_i     (m_haddr),
         .m_htrans_i    (m_htrans),
         .m_hwrite_i    (m_hwrite),
         .m_hsize_i     (m_hsize),
         .m_hlock_i     (m_hlock),
         .m_hwdata_i    (m_hwdata),
         .m_hrdata_o    (m_hrdata),
         .m_hready_o    (m_hready),
         .m_hresp_o     (m_hresp),
         .s_tick_o      (s_tick),
         .s_haddr_o     (s_haddr),
         .s_htrans_o    (s_htrans),
         .s_hwrite_o    (s_hwrite),
         .s_hsize_o     (s_hsize),
         .s_hlock_o     (s_hlock),
         .s_hwdata_o    (s_hwdata),
         .s_hrdata_i    (s_hrdata),
         .s_hreadyout_i (s_hreadyout),
         .s_hresp_i     (s_hresp),
         .s_hready_o    (s_hready)
      );
   end else begin : g_pipe
      ahb_brg_pipe #(.AW(AW), .DW(DW), .RATIO(RATIO)) core_i (
         .clk           (clk),
         .rst_n         (rst_n),
         .m_haddr_i     (m_haddr),
         .m_htrans_i    (m_htrans),
         .m_hwrite_i    (m_hwrite),
         .m_hsize_i     (m_hsize),
         .m_hlock_i     (m_hlock),
         .m_hwdata_i    (m_hwdata),
         .m_hrdata_o    (m_hrdata),
         .m_hready_o    (m_hready),
         .m_hresp_o     (m_hresp),
         .s_tick_o      (s_tick),
         .s_haddr_o     (s_haddr),
         .s_htrans_o    (s_htrans),
         .s_hwrite_o    (s_hwrite),
         .s_hsize_o     (s_hsize),
         .s_hlock_o     (s_hlock),
         .s_hwdata_o    (s_hwdata),
         .s_hrdata_i    (s_hrdata),
         .s_hreadyout_i (s_hreadyout),
         .s_hresp_i     (s_hresp),
         .s_hready_o    (s_hready)
      );
   end

endmodule

// File: tb/ahb_reg_bridge_tb_top.sv
module ahb_reg_bridge_tb_lane #(
   parameter int RATIO  = 1,
   parameter bit BYPASS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   n_total,
   output int   n_bad
);
   localparam bit THRU = BYPASS && (RATIO == 1);

   logic [19:0] m_haddr;
   logic [1:0]  m_htrans;
   logic        m_hwrite;
   logic [1:0]  m_hsize;
   logic        m_hlock;
   logic [31:0] m_hwdata;
   logic [31:0] m_hrdata;
   logic        m_hready, m_hresp, s_tick;
   logic [19:0] s_haddr;
   logic [1:0]  s_htrans;
   logic        s_hwrite;
   logic [1:0]  s_hsize;
   logic        s_hlock;
   logic [31:0] s_hwdata;
   logic [31:0] s_hrdata;
   logic        s_hreadyout, s_hresp, s_hready;

   ahb_reg_bridge #(.AW(20), .DW(32), .RATIO(RATIO), .BYPASS(BYPASS)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
      .m_hlock(m_hlock), .m_hwdata(m_hwdata), .m_hrdata(m_hrdata), .m_hready(m_hready),
      .m_hresp(m_hresp), .s_tick(s_tick), .s_haddr(s_haddr), .s_htrans(s_htrans),
      .s_hwrite(s_hwrite), .s_hsize(s_hsize), .s_hlock(s_hlock), .s_hwdata(s_hwdata),
      .s_hrdata(s_hrdata), .s_hreadyout(s_hreadyout), .s_hresp(s_hresp), .s_hready(s_hready)
   );

   // slave model
   logic [31:0] mem [16];
   logic        sl_dph, sl_err, sl_e2, sl_wr;
   logic [3:0]  sl_cnt, sl_idx, wait_n;
   int          acc_cnt;
   logic [19:0] last_addr;
   logic [1:0]  last_size, last_tr;
   logic        last_lock, last_wr;

   assign s_hreadyout = !sl_dph || ((sl_cnt == 0) && (!sl_err || sl_e2));
   assign s_hresp     = sl_dph && (sl_cnt == 0) && sl_err;
   assign s_hrdata    = mem[sl_idx];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sl_dph <= 1'b0; sl_err <= 1'b0; sl_e2 <= 1'b0; sl_wr <= 1'b0;
         sl_cnt <= '0; sl_idx <= '0; acc_cnt <= 0;
         last_addr <= '0; last_size <= '0; last_tr <= '0; last_lock <= 1'b0; last_wr <= 1'b0;
         for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i;
      end else if (s_tick) begin
         if (sl_dph) begin
            if (sl_cnt != 0) sl_cnt <= sl_cnt - 1'b1;
            else if (sl_err && !sl_e2) sl_e2 <= 1'b1;
            else begin
               if (sl_wr && !sl_err) mem[sl_idx] <= s_hwdata;
               sl_dph <= 1'b0;
            end
         end
         if (s_hready && s_htrans[1]) begin
            sl_dph <= 1'b1; sl_cnt <= wait_n; sl_err <= s_haddr[7]; sl_e2 <= 1'b0;
            sl_wr <= s_hwrite; sl_idx <= s_haddr[5:2]; acc_cnt <= acc_cnt + 1;
            last_addr <= s_haddr; last_size <= s_hsize; last_tr <= s_htrans;
            last_lock <= s_hlock; last_wr <= s_hwrite;
         end
      end
   end

   logic [31:0] exp_mem [16];

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s ratio=%0d bypass=%0d %s act=%0h exp=%0h", req, RATIO, BYPASS, what, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [19:0] addr, input logic [31:0] wd,
                       input logic [1:0] size, input logic lock, input logic [1:0] tr,
                       input int w, input logic err);
      int stall, ticks, acc0, exp_stall;
      logic saw_e1;
      string st_tag;
      acc0 = acc_cnt;
      wait_n = w[3:0];
      @(negedge clk);
      chk("R4", "ready before start", {31'd0, m_hready}, 32'd1);
      m_haddr = addr; m_htrans = tr; m_hwrite = wr; m_hsize = size; m_hlock = lock;
      @(negedge clk);
      m_htrans = 2'b00; m_hwdata = wd;
      stall = 0; ticks = 0; saw_e1 = 1'b0;
      while (!m_hready && stall < 1000) begin
         if (m_hresp) saw_e1 = 1'b1;
         if (s_tick) ticks++;
         stall++;
         @(negedge clk);
      end
      if (THRU) exp_stall = err ? w + 1 : w;
      else exp_stall = err ? 2 + 4 * RATIO + w * RATIO : 1 + 3 * RATIO + w * RATIO;
      st_tag = err ? "R8" : (THRU ? "R2" : (BYPASS ? "R3" : "R4"));
      chk(st_tag, "stall cycles", stall, exp_stall);
      chk("R8", "resp at completion", {31'd0, m_hresp}, {31'd0, err});
      if (err) chk("R8", "first error cycle", {31'd0, saw_e1}, 32'd1);
      if (!wr && !err) chk("R7", "read data", m_hrdata, exp_mem[addr[5:2]]);
      if (!THRU && !err) chk("R1", "tick count", ticks, 3 + w);
      chk("R5", "slave accesses", acc_cnt - acc0, 1);
      chk("R5", "address", {12'd0, last_addr}, {12'd0, addr});
      chk("R5", "size", {30'd0, last_size}, {30'd0, size});
      chk("R5", "lock", {31'd0, last_lock}, {31'd0, lock});
      chk("R5", "write flag", {31'd0, last_wr}, {31'd0, wr});
      if (!THRU) chk("R5", "slave trans code", {30'd0, last_tr}, 32'd2);
      if (wr && !err) exp_mem[addr[5:2]] = wd;
   endtask

   initial begin
      done = 1'b0; n_total = 0; n_bad = 0; wait_n = '0;
      m_haddr = '0; m_htrans = 2'b00; m_hwrite = 1'b0; m_hsize = 2'b00; m_hlock = 1'b0; m_hwdata = '0;
      for (int i = 0; i < 16; i++) exp_mem[i] = 32'hA000_0000 + i;
      @(posedge rst_n);
      @(negedge clk);
      chk("R4", "reset ready", {31'd0, m_hready}, 32'd1);
      chk("R8", "reset resp", {31'd0, m_hresp}, 32'd0);
      chk("R6", "reset slave trans", {30'd0, s_htrans}, 32'd0);
      // R6: busy and idle start nothing
      begin
         int a0;
         a0 = acc_cnt;
         m_haddr = 20'h00010; m_htrans = 2'b01;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R6", "ready during busy", {31'd0, m_hready}, 32'd1);
            chk("R6", "slave trans during busy", {30'd0, s_htrans}, (THRU ? 32'd1 : 32'd0));
         end
         m_htrans = 2'b00;
         repeat (2) @(negedge clk);
         chk("R6", "no slave access on busy/idle", acc_cnt - a0, 0);
      end
      for (int w = 0; w < 3; w++) begin
         for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 2; k++) begin
               logic [19:0] a;
               logic [3:0]  idx;
               idx = 4'(w * 2 + e + 1);
               a = {12'd0, e[0], 1'b0, idx, 2'b00};
               xfer((k == 0), a, 32'h1234_0000 ^ (w << 8) ^ (e << 4) ^ RATIO,
                    2'(w), 1'(k ^ e), (k == 0) ? 2'b10 : 2'b11, w, e[0]);
            end
            // R7: read back the word of this pass after the write attempt
            xfer(1'b0, {12'd0, 1'b0, 1'b0, 4'(w * 2 + e + 1), 2'b00}, 32'h0, 2'b10, 1'b0, 2'b10, 0, 1'b0);
         end
      end
      done = 1'b1;
   end
endmodule

module ahb_reg_bridge_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic d0, d1, d2, d3, d4;
   int   t0, t1, t2, t3, t4, b0, b1, b2, b3, b4;

   ahb_reg_bridge_tb_lane #(.RATIO(1), .BYPASS(1'b1)) lane_thru (.clk(clk), .rst_n(rst_n), .done(d0), .n_total(t0), .n_bad(b0));
   ahb_reg_bridge_tb_lane #(.RATIO(1), .BYPASS(1'b0)) lane_r1 (.clk(clk), .rst_n(rst_n), .done(d1), .n_total(t1), .n_bad(b1));
   ahb_reg_bridge_tb_lane #(.RATIO(2), .BYPASS(1'b0)) lane_r2 (.clk(clk), .rst_n(rst_n), .done(d2), .n_total(t2), .n_bad(b2));
   ahb_reg_bridge_tb_lane #(.RATIO(4), .BYPASS(1'b0)) lane_r4 (.clk(clk), .rst_n(rst_n), .done(d3), .n_total(t3), .n_bad(b3));
   ahb_reg_bridge_tb_lane #(.RATIO(2), .BYPASS(1'b1)) lane_r2b (.clk(clk), .rst_n(rst_n), .done(d4), .n_total(t4), .n_bad(b4));

   initial begin
      int cyc, total, bad;
      cyc = 0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      while (!(d0 && d1 && d2 && d3 && d4) && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      total = t0 + t1 + t2 + t3 + t4;
      bad   = b0 + b1 + b2 + b3 + b4;
      if (!(d0 && d1 && d2 && d3 && d4)) begin
         total++;
         bad++;
         $display("FAIL watchdog all-reqs act=%0d exp=done", cyc);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule